// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the command front end of a parallel NOR flash device. It watches bus write cycles, each carrying an address and a data value, and recognises the multi-cycle unlock-and-command sequences that select an operation: software reset, manufacturer/device ID read, program, whole-chip erase, single-sector erase, and suspending or resuming a sector erase. The block does not hold the array, the high-voltage timing or the status bits. It only tracks which operation is in force and tells an embedded-operation engine what to start.

Each recognised operation produces a one-cycle start strobe together with the captured address, data and sector number. The engine reports completion with a one-cycle done pulse. A bus-width input selects between word addressing and byte addressing. In byte addressing the bus address carries one extra low-order bit, so the unlock addresses and the position of the sector field move with it.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `mode` = 0 (read array) and all five strobes low.
- R2: The first two cycles of every command must be data AAh and then data 55h. In word mode they go to addresses 555h and 2AAh, in byte mode to AAAh and 555h, compared on bus address bits [11:0]. A write with the wrong data, the wrong address or in the wrong order returns `mode` to 0 and raises no strobe.
- R3: After the unlock pair, A0h at the first unlock address followed by one more write raises `start_prog` for exactly one cycle, in the cycle after that write. At the same time `mode` becomes 2 and `op_addr`/`op_data` hold that write's address and data. Any data value is accepted in this cycle, F0h included.
- R4: Unlock, 80h at the first unlock address, unlock again, then 10h at the first unlock address raises `start_chip_erase` and sets `mode` to 3.
- R5: The same six-cycle prefix ending with 30h at any address raises `start_sector_erase` and sets `mode` to 3. `op_sector` holds the sector number A17..A12, which is bus bits [17:12] in word mode and [18:13] in byte mode.
- R6: Unlock followed by 90h at the first unlock address sets `mode` to 1 (ID read).
- R7: A write of F0h to any address, in read or ID mode or part way through a sequence, returns `mode` to 0 and discards the partial sequence.
- R8: While `mode` is 2 (program busy) or 3 (erase busy), every write is ignored, with one exception: B0h during a sector erase. `op_done` ends the busy mode.
- R9: B0h written during a sector erase sets `mode` to 4 (erase suspended) and pulses `suspend_req`. During a chip erase it has no effect.
- R10: While suspended, a full program sequence to a sector other than the one being erased starts a program (`mode` 2), and `op_done` then returns `mode` to 4. A program to the erasing sector is rejected with no strobe. Wrong cycles and F0h leave `mode` at 4.
- R11: While suspended, a single write of 30h to any address pulses `resume_req` and sets `mode` back to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_mode | input | 1 | 1 selects byte addressing, 0 word addressing |
| wr_en | input | 1 | Bus write cycle valid this clock |
| wr_addr | input | ADDR_W (19) | Bus address of the write |
| wr_data | input | DATA_W (16) | Bus data of the write; commands use bits [7:0] |
| op_done | input | 1 | Engine finished the running program or erase |
| mode | output | 3 | 0 read, 1 ID read, 2 program busy, 3 erase busy, 4 erase suspended |
| start_prog | output | 1 | One-cycle program start |
| start_chip_erase | output | 1 | One-cycle chip erase start |
| start_sector_erase | output | 1 | One-cycle sector erase start |
| suspend_req | output | 1 | One-cycle erase suspend request |
| resume_req | output | 1 | One-cycle erase resume request |
| op_addr | output | ADDR_W (19) | Address captured with the last start |
| op_data | output | DATA_W (16) | Data captured with the last start |
| op_sector | output | SEC_W (6) | Sector number captured with the last start |

## Verification
Some properties are checked on every cycle. The strobes are never active together. Each strobe appears only with the mode it implies. Suspend and resume strobes appear only on the erase-to-suspended and suspended-to-erase transitions. A busy mode is left only after a done pulse or, for erase, by suspending. Reset always yields read mode with quiet strobes. The following can only be shown by directed scenarios: correct address and data matching in both bus modes, abort on a wrong cycle, F0h clearing a partial sequence, the contents of the captured address, data and sector, rejection of a program to the erasing sector, and chip erase ignoring B0h.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    localparam int CMP_W = 12;

    localparam logic [7:0] CMD_UNLOCK_A   = 8'hAA;
    localparam logic [7:0] CMD_UNLOCK_B   = 8'h55;
    localparam logic [7:0] CMD_SW_RESET   = 8'hF0;
    localparam logic [7:0] CMD_AUTOSEL    = 8'h90;
    localparam logic [7:0] CMD_PROGRAM    = 8'hA0;
    localparam logic [7:0] CMD_ERASE_PRE  = 8'h80;
    localparam logic [7:0] CMD_CHIP_GO    = 8'h10;
    localparam logic [7:0] CMD_SECT_GO    = 8'h30;
    localparam logic [7:0] CMD_SUSPEND    = 8'hB0;
    localparam logic [7:0] CMD_RESUME     = 8'h30;

    typedef enum logic [2:0] {
        MODE_READ  = 3'd0,
        MODE_ID    = 3'd1,
        MODE_PROG  = 3'd2,
        MODE_ERASE = 3'd3,
        MODE_SUSP  = 3'd4
    } mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_UNL1,
        ST_UNL2,
        ST_PDATA,
        ST_ESET,
        ST_EUNL1,
        ST_EUNL2
    } stage_e;

    typedef enum logic [3:0] {
        EV_NONE,
        EV_ABORT,
        EV_RESET,
        EV_ID,
        EV_PROG,
        EV_CHIP,
        EV_SECT,
        EV_SUSP,
        EV_RESUME
    } event_e;

    typedef struct packed {
        logic prog;
        logic chip;
        logic sect;
        logic susp;
        logic resume;
    } strobe_t;

    function automatic logic [CMP_W-1:0] first_unlock_addr(input logic byte_sel);
        return byte_sel ? 12'hAAA : 12'h555;
    endfunction

    function automatic logic [CMP_W-1:0] second_unlock_addr(input logic byte_sel);
        return byte_sel ? 12'h555 : 12'h2AA;
    endfunction

endpackage

// File: rtl/flash_cmd_addr_map.sv
module flash_cmd_addr_map
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int SEC_W  = 6,
    parameter int SEC_LO = 12
) (
    input  logic              byte_mode,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              hit_first,
    output logic              hit_second,
    output logic [SEC_W-1:0]  sector
);
    localparam int BYTE_LO = SEC_LO + 1;

    logic [CMP_W-1:0] low_bits;

    generate
        if (ADDR_W >= BYTE_LO + SEC_W) begin : g_full
            assign sector = byte_mode ? bus_addr[BYTE_LO +: SEC_W]
                                      : bus_addr[SEC_LO +: SEC_W];
        end else begin : g_word_only
            assign sector = bus_addr[SEC_LO +: SEC_W];
        end
    endgenerate

    assign low_bits   = bus_addr[CMP_W-1:0];
    assign hit_first  = (low_bits == first_unlock_addr(byte_mode));
    assign hit_second = (low_bits == second_unlock_addr(byte_mode));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_cmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       busy,
    input  logic       hit_first,
    input  logic       hit_second,
    input  logic [7:0] cmd,
    output event_e     ev
);
    stage_e stage_q;
    stage_e stage_n;

    always_comb begin
        ev      = EV_NONE;
        stage_n = stage_q;
        if (wr_en) begin
            stage_n = ST_IDLE;
            if (busy) begin
                if (cmd == CMD_SUSPEND) ev = EV_SUSP;
            end else if (stage_q != ST_PDATA && cmd == CMD_SW_RESET) begin
                ev = EV_RESET;
            end else begin
                ev = EV_ABORT;
                case (stage_q)
                    ST_IDLE: begin
                        if (cmd == CMD_UNLOCK_A && hit_first) begin
                            stage_n = ST_UNL1;
                            ev      = EV_NONE;
                        end else if (cmd == CMD_RESUME) begin
                            ev = EV_RESUME;
                        end else if (cmd == CMD_SUSPEND) begin
                            ev = EV_SUSP;
                        end
                    end
                    ST_UNL1: begin
                        if (cmd == CMD_UNLOCK_B && hit_second) begin
                            stage_n = ST_UNL2;
                            ev      = EV_NONE;
                        end
                    end
                    ST_UNL2: begin
                        if (hit_first) begin
                            if (cmd == CMD_AUTOSEL) begin
                                ev = EV_ID;
                            end else if (cmd == CMD_PROGRAM) begin
                                stage_n = ST_PDATA;
                                ev      = EV_NONE;
                            end else if (cmd == CMD_ERASE_PRE) begin
                                stage_n = ST_ESET;
                                ev      = EV_NONE;
                            end
                        end
                    end
                    ST_PDATA: ev = EV_PROG;
                    ST_ESET: begin
                        if (cmd == CMD_UNLOCK_A && hit_first) begin
                            stage_n = ST_EUNL1;
                            ev      = EV_NONE;
                        end
                    end
                    ST_EUNL1: begin
                        if (cmd == CMD_UNLOCK_B && hit_second) begin
                            stage_n = ST_EUNL2;
                            ev      = EV_NONE;
                        end
                    end
                    ST_EUNL2: begin
                        if (cmd == CMD_CHIP_GO && hit_first) ev = EV_CHIP;
                        else if (cmd == CMD_SECT_GO)        ev = EV_SECT;
                    end
                    default: ev = EV_ABORT;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stage_q <= ST_IDLE;
        else     stage_q <= stage_n;
    end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16,
    parameter int SEC_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  event_e            ev,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [SEC_W-1:0]  sector_in,
    input  logic              op_done,
    output mode_e             mode_q,
    output logic              busy,
    output strobe_t           strobe_q,
    output logic [ADDR_W-1:0] op_addr_q,
    output logic [DATA_W-1:0] op_data_q,
    output logic [SEC_W-1:0]  op_sector_q
);
    logic             erase_by_sector_q;
    logic [SEC_W-1:0] erase_sector_q;
    logic             return_susp_q;
    logic             capture;

    assign busy = (mode_q == MODE_PROG) || (mode_q == MODE_ERASE);

    always_comb begin
        capture = 1'b0;
        if (mode_q == MODE_READ || mode_q == MODE_ID)
            capture = (ev == EV_PROG) || (ev == EV_CHIP) || (ev == EV_SECT);
        else if (mode_q == MODE_SUSP)
            capture = (ev == EV_PROG) && (sector_in != erase_sector_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_addr_q   <= '0;
            op_data_q   <= '0;
            op_sector_q <= '0;
        end else if (capture) begin
            op_addr_q   <= wr_addr;
            op_data_q   <= wr_data;
            op_sector_q <= sector_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q            <= MODE_READ;
            strobe_q          <= '0;
            erase_by_sector_q <= 1'b0;
            erase_sector_q    <= '0;
            return_susp_q     <= 1'b0;
        end else begin
            strobe_q <= '0;
            case (mode_q)
                MODE_READ, MODE_ID: begin
                    case (ev)
                        EV_RESET, EV_ABORT, EV_RESUME, EV_SUSP: mode_q <= MODE_READ;
                        EV_ID: mode_q <= MODE_ID;
                        EV_PROG: begin
                            mode_q        <= MODE_PROG;
                            strobe_q.prog <= 1'b1;
                            return_susp_q <= 1'b0;
                        end
                        EV_CHIP: begin
                            mode_q            <= MODE_ERASE;
                            strobe_q.chip     <= 1'b1;
                            erase_by_sector_q <= 1'b0;
                        end
                        EV_SECT: begin
                            mode_q            <= MODE_ERASE;
                            strobe_q.sect     <= 1'b1;
                            erase_by_sector_q <= 1'b1;
                            erase_sector_q    <= sector_in;
                        end
                        default: ;
                    endcase
                end
                MODE_PROG: begin
                    if (op_done) mode_q <= return_susp_q ? MODE_SUSP : MODE_READ;
                end
                MODE_ERASE: begin
                    if (op_done) begin
                        mode_q <= MODE_READ;
                    end else if (ev == EV_SUSP && erase_by_sector_q) begin
                        mode_q        <= MODE_SUSP;
                        strobe_q.susp <= 1'b1;
                    end
                end
                MODE_SUSP: begin
                    if (ev == EV_PROG && sector_in != erase_sector_q) begin
                        mode_q        <= MODE_PROG;
                        strobe_q.prog <= 1'b1;
                        return_susp_q <= 1'b1;
                    end else if (ev == EV_RESUME) begin
                        mode_q          <= MODE_ERASE;
                        strobe_q.resume <= 1'b1;
                    end
                end
                default: mode_q <= MODE_READ;
            endcase
        end
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import flash_cmd_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 16,
    parameter int SEC_W  = 6,
    parameter int SEC_LO = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_mode,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              op_done,
    output logic [2:0]        mode,
    output logic              start_prog,
    output logic              start_chip_erase,
    output logic              start_sector_erase,
    output logic              suspend_req,
    output logic              resume_req,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data,
    output logic [SEC_W-1:0]  op_sector
);
    logic             hit_first;
    logic             hit_second;
    logic [SEC_W-1:0] sector;
    logic             busy;
    event_e           ev;
    mode_e            mode_q;
    strobe_t          strobe_q;

    flash_cmd_addr_map #(
        .ADDR_W (ADDR_W),
        .SEC_W  (SEC_W),
        .SEC_LO (SEC_LO)
    ) addr_map_i (
        .byte_mode  (byte_mode),
        .bus_addr   (wr_addr),
        .hit_first  (hit_first),
        .hit_second (hit_second),
        .sector     (sector)
    );

    flash_cmd_seq seq_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .busy       (busy),
        .hit_first  (hit_first),
        .hit_second (hit_second),
        .cmd        (wr_data[7:0]),
        .ev         (ev)
    );

    flash_cmd_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .SEC_W  (SEC_W)
    ) ctrl_i (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .sector_in   (sector),
        .op_done     (op_done),
        .mode_q      (mode_q),
        .busy        (busy),
        .strobe_q    (strobe_q),
        .op_addr_q   (op_addr),
        .op_data_q   (op_data),
        .op_sector_q (op_sector)
    );

    assign mode               = mode_q;
    assign start_prog         = strobe_q.prog;
    assign start_chip_erase   = strobe_q.chip;
    assign start_sector_erase = strobe_q.sect;
    assign suspend_req        = strobe_q.susp;
    assign resume_req         = strobe_q.resume;

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       op_done,
    input logic [2:0] mode,
    input logic       start_prog,
    input logic       start_chip_erase,
    input logic       start_sector_erase,
    input logic       suspend_req,
    input logic       resume_req
);
    logic [4:0] strobes;
    assign strobes = {start_prog, start_chip_erase, start_sector_erase, suspend_req, resume_req};

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (mode == 3'd0 && strobes == 5'b0));

    assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobes));

    assert_prog_mode_R3: assert property (@(posedge clk) disable iff (rst)
        start_prog |-> mode == 3'd2);

    assert_chip_mode_R4: assert property (@(posedge clk) disable iff (rst)
        start_chip_erase |-> mode == 3'd3);

    assert_sect_mode_R5: assert property (@(posedge clk) disable iff (rst)
        start_sector_erase |-> mode == 3'd3);

    assert_prog_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) == 3'd2 && mode != 3'd2) |-> $past(op_done));

    assert_erase_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(mode) == 3'd3 && mode != 3'd3) |-> ($past(op_done) || suspend_req));

    assert_suspend_edge_R9: assert property (@(posedge clk) disable iff (rst)
        suspend_req |-> (mode == 3'd4 && $past(mode) == 3'd3));

    assert_resume_edge_R11: assert property (@(posedge clk) disable iff (rst)
        resume_req |-> (mode == 3'd3 && $past(mode) == 3'd4));

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk chk_i (
    .clk                (clk),
    .rst                (rst),
    .op_done            (op_done),
    .mode               (mode),
    .start_prog         (start_prog),
    .start_chip_erase   (start_chip_erase),
    .start_sector_erase (start_sector_erase),
    .suspend_req        (suspend_req),
    .resume_req         (resume_req)
);

// File: tb/flash_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;
    localparam int ADDR_W = 19;
    localparam int DATA_W = 16;
    localparam int SEC_W  = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              byte_mode = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              op_done = 1'b0;
    logic [2:0]        mode;
    logic              start_prog, start_chip_erase, start_sector_erase;
    logic              suspend_req, resume_req;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_data;
    logic [SEC_W-1:0]  op_sector;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    flash_cmd_decoder dut_i (
        .clk(clk), .rst(rst), .byte_mode(byte_mode), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .op_done(op_done), .mode(mode),
        .start_prog(start_prog), .start_chip_erase(start_chip_erase),
        .start_sector_erase(start_sector_erase), .suspend_req(suspend_req),
        .resume_req(resume_req), .op_addr(op_addr), .op_data(op_data),
        .op_sector(op_sector)
    );

    // strobe vector order: prog, chip, sector, suspend, resume
    function automatic logic [4:0] strobes();
        return {start_prog, start_chip_erase, start_sector_erase, suspend_req, resume_req};
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
    endtask

    task automatic unlock();
        if (byte_mode) begin wr(19'hAAA, 16'hAA); wr(19'h555, 16'h55); end
        else           begin wr(19'h555, 16'hAA); wr(19'h2AA, 16'h55); end
    endtask

    function automatic logic [ADDR_W-1:0] ua();
        return byte_mode ? 19'hAAA : 19'h555;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1", "mode", mode, 0);
        check("R1", "strobes", strobes(), 0);
    endtask

    task automatic t_word_program();
        byte_mode = 1'b0;
        unlock(); wr(ua(), 16'hA0); wr(19'h23456, 16'hBEEF);
        check("R3", "strobes", strobes(), 5'b10000);
        check("R3", "mode", mode, 2);
        check("R3", "op_addr", op_addr, 19'h23456);
        check("R3", "op_data", op_data, 16'hBEEF);
        wr(19'h0, 16'hF0);
        check("R8", "mode after F0 while busy", mode, 2);
        check("R8", "strobes while busy", strobes(), 0);
        done_pulse();
        check("R8", "mode after done", mode, 0);
        unlock(); wr(ua(), 16'hA0); wr(19'h100, 16'h00F0);
        check("R3", "op_data F0 accepted", op_data, 16'h00F0);
        check("R3", "mode F0 data", mode, 2);
        done_pulse();
    endtask

    task automatic t_byte_program();
        byte_mode = 1'b1;
        unlock(); wr(ua(), 16'hA0); wr(19'h40001, 16'h005A);
        check("R2", "byte mode prog strobe", strobes(), 5'b10000);
        check("R2", "byte mode op_addr", op_addr, 19'h40001);
        done_pulse();
        byte_mode = 1'b0;
    endtask

    task automatic t_id_and_abort();
        byte_mode = 1'b0;
        unlock(); wr(19'h555, 16'h90);
        check("R6", "id mode", mode, 1);
        wr(19'h555, 16'hAA); wr(19'h555, 16'h55);
        check("R2", "wrong second address", mode, 0);
        byte_mode = 1'b1;
        unlock(); wr(ua(), 16'h90);
        check("R6", "byte id mode", mode, 1);
        wr(19'h555, 16'hAA);
        check("R2", "word address in byte mode", mode, 0);
        byte_mode = 1'b0;
        unlock(); wr(19'h555, 16'h77);
        check("R2", "bad command data mode", mode, 0);
        check("R2", "bad command strobes", strobes(), 0);
        unlock(); wr(19'h555, 16'h90);
        wr(19'h1234, 16'hF0);
        check("R7", "F0 leaves id", mode, 0);
        unlock(); wr(19'h0, 16'hF0); wr(19'h555, 16'hA0); wr(19'h10, 16'h1);
        check("R7", "F0 cleared partial seq", strobes(), 0);
        check("R7", "F0 cleared partial mode", mode, 0);
    endtask

    task automatic t_chip_erase();
        byte_mode = 1'b0;
        unlock(); wr(19'h555, 16'h80); unlock(); wr(19'h555, 16'h20);
        check("R2", "bad erase final cycle", strobes(), 0);
        check("R2", "bad erase final mode", mode, 0);
        unlock(); wr(19'h555, 16'h80); unlock(); wr(19'h555, 16'h10);
        check("R4", "chip strobe", strobes(), 5'b01000);
        check("R4", "chip mode", mode, 3);
        wr(19'h0, 16'hB0);
        check("R9", "B0 in chip erase strobes", strobes(), 0);
        check("R9", "B0 in chip erase mode", mode, 3);
        done_pulse();
        check("R8", "chip done", mode, 0);
    endtask

    task automatic t_sector_suspend();
        byte_mode = 1'b0;
        unlock(); wr(19'h555, 16'h80); unlock(); wr(19'h05000, 16'h30);
        check("R5", "sector strobe", strobes(), 5'b00100);
        check("R5", "sector mode", mode, 3);
        check("R5", "op_sector word", op_sector, 6'd5);
        wr(19'h0, 16'hB0);
        check("R9", "suspend strobe", strobes(), 5'b00010);
        check("R9", "suspended mode", mode, 4);
        unlock(); wr(19'h555, 16'hA0); wr(19'h09010, 16'h1234);
        check("R10", "prog other sector strobe", strobes(), 5'b10000);
        check("R10", "prog other sector mode", mode, 2);
        check("R10", "prog other sector addr", op_addr, 19'h09010);
        done_pulse();
        check("R10", "back to suspended", mode, 4);
        unlock(); wr(19'h555, 16'hA0); wr(19'h05ABC, 16'h4321);
        check("R10", "prog erasing sector rejected", strobes(), 0);
        check("R10", "mode after reject", mode, 4);
        check("R10", "op_addr kept", op_addr, 19'h09010);
        wr(19'h555, 16'h77); wr(19'h0, 16'hF0);
        check("R10", "wrong cycle and F0 keep suspend", mode, 4);
        wr(19'h0, 16'h30);
        check("R11", "resume strobe", strobes(), 5'b00001);
        check("R11", "resume mode", mode, 3);
        done_pulse();
        check("R8", "sector done", mode, 0);
    endtask

    task automatic t_byte_sector_and_reset();
        byte_mode = 1'b1;
        unlock(); wr(ua(), 16'h80); unlock(); wr(19'h54000, 16'h30);
        check("R5", "op_sector byte", op_sector, 6'h2A);
        check("R5", "byte sector mode", mode, 3);
        do_reset();
        check("R1", "reset mid erase", mode, 0);
        byte_mode = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_word_program();
        t_byte_program();
        t_id_and_abort();
        t_chip_erase();
        t_sector_suspend();
        t_byte_sector_and_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule